// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of a network port and decides, once per frame, whether the frame should go on to the host or be thrown away. It watches a byte stream that carries start-of-frame and end-of-frame markers. It gathers the first six bytes, which form the destination address, and issues a single accept-or-drop verdict. Only accepted frames raise an event toward the host, so rejected traffic costs the host nothing.

Unicast and broadcast addresses are matched exactly. The unicast match is against a station address supplied on an input. Multicast addresses are admitted through a 64-entry hash bitmap instead of an exact list. Many groups can therefore share a small table, at the price of occasionally admitting a group the station never joined. The bitmap is written one entry at a time through a small write port, and it can change while traffic is flowing. A promiscuous input admits every complete frame. A frame that ends before its address is complete is dropped and marked as a runt.

Top module: `dst_addr_filter`

## Requirements
- R1: While `rst_n` is low on a clock edge, `dec_valid`, `dec_accept`, `runt` and `host_event` are 0 after that edge, and every entry of the hash bitmap is cleared.
- R2: A complete address equal to `station_addr` is accepted. The first byte received is compared with `station_addr[47:40]`, and the sixth byte with `station_addr[7:0]`.
- R3: The all-ones address FF:FF:FF:FF:FF:FF is always accepted.
- R4: A complete address that is not accepted by any rule gives `dec_valid`=1 with `dec_accept`=0, and `host_event` stays 0.
- R5: An address is multicast when bit 0 of its first byte is 1. A multicast address is accepted when the bitmap entry at its hash index is 1. The index is bits [31:26] of the Ethernet CRC-32 of the six address bytes in arrival order: reflected polynomial 0xEDB88320, initial value all ones, LSB of each byte first, result complemented.
- R6: A clock edge with `tbl_we`=1 stores `tbl_bit` into bitmap entry `tbl_idx`. Decisions made on later edges see the new value, so entries can be set and cleared while frames are running.
- R7: A multicast address that was never added, but whose hash index equals that of an added group, is accepted.
- R8: With `promisc`=1, every frame that delivers six address bytes is accepted.
- R9: When `in_eof` arrives on any of the first five bytes of a frame, the frame gets `dec_valid`=1, `dec_accept`=0 and `runt`=1. These appear in the cycle after the edge that took the last byte, and `promisc` has no effect on this outcome.
- R10: For a complete frame, `dec_valid` is high for exactly one cycle. That cycle is the one following the clock edge that takes the sixth byte. Bytes after the sixth produce no further verdict.
- R11: A byte carrying `in_sof` always restarts address collection, even in the middle of an unfinished address. The earlier partial frame then gets no verdict.
- R12: `host_event` is 1 exactly in the cycles where `dec_valid` and `dec_accept` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Received frame byte |
| station_addr | input | 48 | Own unicast address, first byte in bits 47:40 |
| promisc | input | 1 | Accept every complete frame |
| tbl_we | input | 1 | Write one entry of the multicast bitmap |
| tbl_idx | input | 6 | Bitmap entry written |
| tbl_bit | input | 1 | Value written to the entry |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 drop |
| runt | output | 1 | Verdict is for a frame shorter than six bytes |
| host_event | output | 1 | Pulse toward the host for an accepted frame |

## Verification
A complete frame's verdict is due one register stage after the clock edge that takes the sixth byte. A runt's verdict is due one stage after the edge that takes the byte carrying `in_eof`. A bitmap write takes effect from the edge after it is applied. The bench drives each byte on the falling edge and samples the outputs 1 ns after the following rising edge. It records the byte position at which `dec_valid` was seen, and then compares that position and the pulse count with the value the requirements predict. After every frame it runs one extra idle cycle to catch a stray or repeated strobe.

// File: rtl/afilt_pkg.sv
// Package: shared constants and the byte-wise CRC-32 step used for the
// multicast hash. Assumes Ethernet bit order (LSB of each byte first).
package afilt_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = MAC_BYTES * 8;
    localparam int HASH_W    = 6;
    localparam int CRC_W     = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_INIT      = 32'hFFFF_FFFF;

    // Advance a reflected CRC-32 by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc32_byte(input logic [CRC_W-1:0] c,
                                                    input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/afilt_collect.sv
// Address collector: counts the first MAC_BYTES bytes of each frame, shifts
// them into a register and runs the CRC alongside. Assumes in_sof/in_eof are
// only meaningful with in_valid. Presents the full address and CRC
// combinationally on the byte that completes it, or flags an early end.
module afilt_collect
    import afilt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_byte,
    output logic [MAC_W-1:0] addr_full,
    output logic [CRC_W-1:0] crc_full,
    output logic             addr_done,
    output logic             runt_end
);
    localparam int CNT_W = $clog2(MAC_BYTES);
    localparam int SH_W  = MAC_W - 8;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MAC_BYTES - 1);

    logic [CNT_W-1:0] cnt;      // bytes taken in current frame, 0 = idle
    logic [SH_W-1:0]  shift_q;
    logic [CRC_W-1:0] crc_q;
    logic             active;
    logic [CNT_W-1:0] pos;
    logic [CRC_W-1:0] crc_base;

    // Purpose: locate this byte inside the address field.
    always_comb begin
        active    = in_valid && (in_sof || (cnt != '0));
        pos       = in_sof ? '0 : cnt;
        crc_base  = in_sof ? CRC_INIT : crc_q;
        addr_done = active && (pos == LAST_POS);
        runt_end  = active && in_eof && (pos != LAST_POS);
        addr_full = {shift_q, in_byte};
        crc_full  = crc32_byte(crc_base, in_byte);
    end

    // Purpose: byte counter, address shifter and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            shift_q <= '0;
            crc_q   <= CRC_INIT;
        end else if (active) begin
            if (in_eof || (pos == LAST_POS)) cnt <= '0;
            else                             cnt <= pos + CNT_W'(1);
            shift_q <= {shift_q[SH_W-9:0], in_byte};
            crc_q   <= crc_full;
        end
    end
endmodule

// File: rtl/afilt_hash.sv
// Multicast hash bitmap: 2**IDX_W single-bit entries, one written per cycle,
// read combinationally. Assumes a write and a read in the same cycle return
// the old value.
module afilt_hash #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] map_q;

    // Purpose: one flop per entry, each loaded when addressed.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                                    map_q[g] <= 1'b0;
            else if (we && (widx == IDX_W'(g)))            map_q[g] <= wbit;
        end
    end

    // Purpose: select the entry being looked up.
    always_comb rbit = map_q[ridx];
endmodule

// File: rtl/dst_addr_filter.sv
// Destination address filter top: combines the collector and hash bitmap,
// forms the verdict on the byte that completes the address (or ends a runt)
// and registers it as a one-cycle strobe. Assumes station_addr and promisc
// are stable around the sixth byte.
module dst_addr_filter
    import afilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_byte,
    input  logic [47:0]       station_addr,
    input  logic              promisc,
    input  logic              tbl_we,
    input  logic [5:0]        tbl_idx,
    input  logic              tbl_bit,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              runt,
    output logic              host_event
);
    logic [MAC_W-1:0]  addr_full;
    logic [CRC_W-1:0]  crc_full;
    logic              addr_done;
    logic              runt_end;
    logic [HASH_W-1:0] hash_idx;
    logic              hash_hit;
    logic              is_mcast;
    logic              is_bcast;
    logic              is_own;
    logic              accept_now;

    afilt_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_byte   (in_byte),
        .addr_full (addr_full),
        .crc_full  (crc_full),
        .addr_done (addr_done),
        .runt_end  (runt_end)
    );

    afilt_hash #(.IDX_W(HASH_W)) u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wbit  (tbl_bit),
        .ridx  (hash_idx),
        .rbit  (hash_hit)
    );

    // Purpose: classify the address and apply the acceptance rules.
    always_comb begin
        logic [CRC_W-1:0] crc_fin;
        crc_fin    = ~crc_full;
        hash_idx   = crc_fin[CRC_W-1 -: HASH_W];
        is_mcast   = addr_full[MAC_W-8];
        is_bcast   = &addr_full;
        is_own     = (addr_full == station_addr);
        accept_now = promisc || is_own || is_bcast || (is_mcast && hash_hit);
    end

    // Purpose: register the verdict strobe, runt flag and host event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            runt       <= 1'b0;
            host_event <= 1'b0;
        end else begin
            dec_valid  <= addr_done || runt_end;
            dec_accept <= addr_done && accept_now;
            runt       <= runt_end;
            host_event <= addr_done && accept_now;
        end
    end
endmodule

// File: rtl/afilt_checks.sv
// Checker: port-level properties of the filter verdict, bound to the top.
module afilt_checks (
    input logic clk,
    input logic rst_n,
    input logic promisc,
    input logic dec_valid,
    input logic dec_accept,
    input logic runt,
    input logic host_event
);
    // R1: reset clears the verdict outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dec_valid && !host_event && !runt));

    // R12: an event only accompanies an accepting verdict
    a_r12_event_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        host_event |-> (dec_valid && dec_accept));

    // R12: an accepting verdict always raises the event
    a_r12_accept_raises_event: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> host_event);

    // R9: a runt verdict is always a drop
    a_r9_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        runt |-> (dec_valid && !dec_accept));

    // R8: promiscuous mode accepts any complete frame
    a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !runt && $past(promisc)) |-> dec_accept);
endmodule

bind dst_addr_filter afilt_checks i_afilt_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .promisc    (promisc),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .runt       (runt),
    .host_event (host_event)
);

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_byte;
    logic [47:0] station_addr;
    logic        promisc;
    logic        tbl_we;
    logic [5:0]  tbl_idx;
    logic        tbl_bit;
    logic        dec_valid, dec_accept, runt, host_event;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] GRP_A = 48'h01_00_5E_00_00_01;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .station_addr(station_addr),
        .promisc(promisc), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_bit(tbl_bit),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .runt(runt),
        .host_event(host_event)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Hash index model: bit-serial Ethernet CRC over six bytes, first byte first.
    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        c = ~c;
        return c[31:26];
    endfunction

    // Drive one frame of len bytes and check the verdict timing and value.
    task automatic send_frame(input logic [47:0] da, input int len,
                              input bit exp_acc, input bit exp_runt, input string req);
        int pulses = 0;
        int at = -1;
        bit acc = 0, rn = 0, ev_bad = 0;
        int exp_at = (len < 6) ? len - 1 : 5;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_byte  = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
            @(posedge clk); #1;
            if (dec_valid) begin
                pulses++; at = i; acc = dec_accept; rn = runt;
                if (host_event != dec_accept) ev_bad = 1;
            end else if (host_event) ev_bad = 1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(posedge clk); #1;
        if (dec_valid) pulses++;
        if (host_event) ev_bad = 1;
        check(pulses == 1, req, "verdict strobe count", pulses, 1);
        check(at == exp_at, req, "verdict byte position", at, exp_at);
        check(acc == exp_acc, req, "accept", acc, exp_acc);
        check(rn == exp_runt, req, "runt flag", rn, exp_runt);
        check(!ev_bad, "R12", "host_event mismatch", ev_bad, 0);
    endtask

    task automatic write_tbl(input logic [5:0] idx, input logic val);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_bit = val;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!dec_valid && !dec_accept && !runt && !host_event, "R1",
              "outputs after reset", {dec_valid, dec_accept, runt, host_event}, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_unicast;
        send_frame(OWN, 14, 1, 0, "R2");
        send_frame(OTHER, 14, 0, 0, "R4");
    endtask

    task automatic t_broadcast;
        send_frame(BCAST, 8, 1, 0, "R3");
    endtask

    task automatic t_multicast;
        logic [47:0] alias_g = GRP_A;
        logic [47:0] miss_g  = GRP_A;
        logic [5:0]  ia = hash_of(GRP_A);
        bit found_alias = 0, found_miss = 0;
        for (int n = 2; n < 4000 && !(found_alias && found_miss); n++) begin
            logic [47:0] cand = {32'h01_00_5E_00, 16'(n)};
            if (!found_alias && hash_of(cand) == ia) begin alias_g = cand; found_alias = 1; end
            if (!found_miss && hash_of(cand) != ia)  begin miss_g = cand;  found_miss = 1; end
        end
        send_frame(GRP_A, 10, 0, 0, "R5");   // empty bitmap (R1 clear)
        write_tbl(ia, 1'b1);
        send_frame(GRP_A, 10, 1, 0, "R5");
        send_frame(miss_g, 10, 0, 0, "R5");
        check(found_alias, "R7", "alias search", found_alias, 1);
        send_frame(alias_g, 10, 1, 0, "R7");
        write_tbl(ia, 1'b0);
        send_frame(GRP_A, 10, 0, 0, "R6");
    endtask

    task automatic t_promisc;
        @(negedge clk); promisc = 1'b1;
        send_frame(OTHER, 9, 1, 0, "R8");
        send_frame(48'h01_23_45_67_89_AB, 6, 1, 0, "R8");
        send_frame(OTHER, 3, 0, 1, "R9");   // promisc does not rescue a runt
        @(negedge clk); promisc = 1'b0;
    endtask

    task automatic t_runt;
        send_frame(OWN, 4, 0, 1, "R9");
        send_frame(BCAST, 1, 0, 1, "R9");
        send_frame(OWN, 5, 0, 1, "R9");
    endtask

    task automatic t_long;
        send_frame(OWN, 40, 1, 0, "R10");
    endtask

    task automatic t_restart;
        int seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0;
            in_byte = OTHER[47-8*i -: 8];
            @(posedge clk); #1;
            if (dec_valid) seen++;
        end
        check(seen == 0, "R11", "strobe during abandoned prefix", seen, 0);
        send_frame(OWN, 8, 1, 0, "R11");
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_byte = '0;
        station_addr = OWN; promisc = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_bit = 1'b0;
        t_reset();
        t_unicast();
        t_broadcast();
        t_multicast();
        t_promisc();
        t_runt();
        t_long();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule